// File: doc/BRIEF.md
# Vectoring CORDIC Magnitude and Phase Unit

The block turns a signed Cartesian sample, a real part and an imaginary part, into an unsigned magnitude and an unsigned phase. The phase is given as a fraction of one full turn, so that half a turn stands for 180 degrees. Each sample is first rotated by a multiple of a quarter turn so that it lies in the first quadrant. A chain of shift-and-add iterations then drives the imaginary part towards zero and adds up the elementary angles. The quarter-turn offset is loaded into the angle accumulator at the start, so it is carried through the whole computation.

A parameter picks one of two build forms. The pipelined form gives every iteration its own one or two register stages and takes a sample on every clock. The serial form runs all iterations on one shared datapath and lowers its ready output while a sample is in flight. The iterations scale the vector length by the CORDIC gain K. An optional constant multiplier removes this gain. At the output, rounding or truncation is selectable, and so is saturation or wrap-around of the magnitude.

Top module: `cordic_polar`

## Requirements
- R1: After a synchronous reset, `out_valid` is low and `in_ready` is high, in both build forms.
- R2: With gain compensation on, `out_mag` lies within 3 LSB of sqrt(re^2+im^2). The output LSB equals the input LSB.
- R3: `out_phase` lies within 4 LSB of (atan2(im,re)/2pi mod 1)·2^PH_W. This holds in all four quadrants and on the axes: 0x0000 on the positive real axis, 0x4000 on the positive imaginary axis, 0x8000 on the negative real axis and 0xC000 on the negative imaginary axis (PH_W=16).
- R4: In the pipelined form `in_ready` stays high and a sample is accepted on every clock. Each sample gives exactly one `out_valid` pulse of one cycle, in input order, ITERS·REGS_PER_ITER+1 clock edges after the edge that accepted it.
- R5: In the serial form each accepted sample gives exactly one `out_valid` pulse of one cycle, ITERS+1 clock edges after the edge that accepted it.
- R6: In the serial form `in_ready` is low for exactly ITERS clocks after an acceptance. An `in_valid` pulse during that window is ignored: it produces no output and does not disturb the sample in flight.
- R7: With gain compensation off, `out_mag` lies within 3 LSB of K·sqrt(re^2+im^2), where K is the product over i=0..ITERS-1 of sqrt(1+2^-2i).
- R8: With saturation on, a magnitude above 2^MAG_W-1 is output as 2^MAG_W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_re | input | IN_W | Signed real part |
| in_im | input | IN_W | Signed imaginary part |
| in_valid | input | 1 | Input sample strobe |
| in_ready | output | 1 | High when a sample can be taken (always high when pipelined) |
| out_mag | output | MAG_W | Unsigned magnitude |
| out_phase | output | PH_W | Unsigned phase in turns |
| out_valid | output | 1 | Output strobe, one cycle per sample |

## Verification
The pipelined build receives a back-to-back burst that covers the four axis directions, one point inside each quadrant and the most negative corner. The axis points show whether the quarter-turn fold picks the right offset at the sign boundaries. The off-axis points show whether the iterations converge, and the burst shows whether ordering and the fixed latency hold under full throughput. The serial build, without gain compensation, shows whether the gain K appears in the result and how long ready stays low. A pulse on in_valid while the serial build is busy must not produce a second result, and the corner input must clamp to full scale.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // elementary angle atan(2^-idx) expressed in turns, scaled by 2^w
  function automatic int atan_turns(input int idx, input int w);
    real a;
    a = $atan(2.0 ** (-idx)) / (2.0 * 3.14159265358979);
    return $rtoi(a * (2.0 ** w) + 0.5);
  endfunction

  // reciprocal of the accumulated CORDIC gain, scaled by 2^w
  function automatic int inv_gain(input int n, input int w);
    real k;
    k = 1.0;
    for (int i = 0; i < n; i++) k = k * $sqrt(1.0 + 2.0 ** (-2 * i));
    return $rtoi((2.0 ** w) / k + 0.5);
  endfunction

endpackage

// File: rtl/cordic_fold.sv
module cordic_fold #(
  parameter int IN_W = 16,
  parameter int XW   = 22,
  parameter int ZW   = 20,
  parameter int FG   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take_i,
  input  logic [IN_W-1:0]      re_i,
  input  logic [IN_W-1:0]      im_i,
  output logic                 vld_o,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic [ZW-1:0]        z_o
);
  localparam int EXT = XW - IN_W - 1 - FG;

  logic signed [IN_W:0] ie, qe, a, b;
  logic [1:0]           quad;

  always_comb begin
    ie = {re_i[IN_W-1], re_i};
    qe = {im_i[IN_W-1], im_i};
    unique case ({re_i[IN_W-1], im_i[IN_W-1]})
      2'b00:   begin a = ie;  b = qe;  quad = 2'd0; end
      2'b10:   begin a = qe;  b = -ie; quad = 2'd1; end
      2'b11:   begin a = -ie; b = -qe; quad = 2'd2; end
      default: begin a = -qe; b = ie;  quad = 2'd3; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (take_i) begin
      x_o <= {{EXT{a[IN_W]}}, a, {FG{1'b0}}};
      y_o <= {{EXT{b[IN_W]}}, b, {FG{1'b0}}};
      z_o <= {quad, {(ZW-2){1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= take_i;
  end

  AST_FOLD_Q0: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (!x_o[XW-1] && !y_o[XW-1])); // R3

endmodule

// File: rtl/cordic_iter.sv
module cordic_iter #(
  parameter int XW = 22,
  parameter int ZW = 20,
  parameter int SW = 4
) (
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic [ZW-1:0]        z_i,
  input  logic [SW-1:0]        sh_i,
  input  logic [ZW-1:0]        atan_i,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic [ZW-1:0]        z_o
);
  logic signed [XW-1:0] xs, ys;

  always_comb begin
    xs = x_i >>> sh_i;
    ys = y_i >>> sh_i;
    if (!y_i[XW-1]) begin
      x_o = x_i + ys;
      y_o = y_i - xs;
      z_o = z_i + atan_i;
    end else begin
      x_o = x_i - ys;
      y_o = y_i + xs;
      z_o = z_i - atan_i;
    end
  end

endmodule

// File: rtl/cordic_out.sv
module cordic_out #(
  parameter int XW        = 22,
  parameter int ZW        = 20,
  parameter int FG        = 4,
  parameter int PG        = 4,
  parameter int MAG_W     = 16,
  parameter int PH_W      = 16,
  parameter int ITERS     = 16,
  parameter int GAIN_W    = 18,
  parameter bit GAIN_COMP = 1'b1,
  parameter bit ROUND     = 1'b1,
  parameter bit SATURATE  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic [ZW-1:0]        z_i,
  output logic [MAG_W-1:0]     mag_o,
  output logic [PH_W-1:0]      ph_o,
  output logic                 vld_o
);
  localparam int MW   = XW - FG;
  localparam int KINV = cordic_pkg::inv_gain(ITERS, GAIN_W - 1);
  localparam logic signed [XW-1:0] HALF_M = ROUND ? (XW'(1) << (FG - 1)) : '0;
  localparam logic [ZW-1:0]        HALF_Z = ROUND ? (ZW'(1) << (PG - 1)) : '0;
  localparam logic signed [MW+MAG_W:0] MMAX = (MW+MAG_W+1)'({MAG_W{1'b1}});

  logic signed [XW-1:0]     xg, xr;
  logic signed [MW-1:0]     mi;
  logic signed [MW+MAG_W:0] mw;
  logic [MAG_W-1:0]         mag_n;
  logic [ZW-1:0]            za;

  if (GAIN_COMP) begin : g_gain
    logic signed [XW+GAIN_W-1:0] prod;
    assign prod = x_i * $signed(GAIN_W'(KINV));
    assign xg   = XW'(prod >>> (GAIN_W - 1));
  end else begin : g_raw
    assign xg = x_i;
  end

  always_comb begin
    xr = xg + HALF_M;
    mi = MW'(xr >>> FG);
    mw = (MW+MAG_W+1)'(mi);
    if (SATURATE && mw < 0)         mag_n = '0;
    else if (SATURATE && mw > MMAX) mag_n = '1;
    else                            mag_n = MAG_W'(mi);
    za = z_i + HALF_Z;
  end

  always_ff @(posedge clk) begin
    if (vld_i) begin
      mag_o <= mag_n;
      ph_o  <= PH_W'(za >> PG);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  logic signed [XW:0] y_abs, y_lim;
  assign y_abs = y_i[XW-1] ? -(XW+1)'(y_i) : (XW+1)'(y_i);
  assign y_lim = (XW+1)'(x_i >>> (ITERS - 3)) + (XW+1)'(4 * ITERS);

  AST_MAG_IN_POS: assert property (@(posedge clk) disable iff (rst)
    vld_i |-> !x_i[XW-1]); // R2
  AST_RESIDUE: assert property (@(posedge clk) disable iff (rst)
    vld_i |-> (y_abs <= y_lim)); // R3

endmodule

// File: rtl/cordic_polar.sv
module cordic_polar #(
  parameter int IN_W          = 16,
  parameter int MAG_W         = 16,
  parameter int PH_W          = 16,
  parameter int ITERS         = 16,
  parameter int FRAC_GUARD    = 4,
  parameter int PH_GUARD      = 4,
  parameter int GAIN_W        = 18,
  parameter bit GAIN_COMP     = 1'b1,
  parameter bit ROUND         = 1'b1,
  parameter bit SATURATE      = 1'b1,
  parameter bit SERIAL        = 1'b0,
  parameter int REGS_PER_ITER = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_re,
  input  logic [IN_W-1:0]  in_im,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [MAG_W-1:0] out_mag,
  output logic [PH_W-1:0]  out_phase,
  output logic             out_valid
);
  localparam int XW = IN_W + 2 + FRAC_GUARD;
  localparam int ZW = PH_W + PH_GUARD;
  localparam int SW = (ITERS > 1) ? $clog2(ITERS) : 1;

  logic [ZW-1:0] atan_tab [ITERS];
  for (genvar g = 0; g < ITERS; g++) begin : g_tab
    assign atan_tab[g] = ZW'(cordic_pkg::atan_turns(g, ZW));
  end

  logic                 take, fv, rv;
  logic signed [XW-1:0] fx, fy, rx, ry;
  logic [ZW-1:0]        fz, rz;

  assign take = in_valid & in_ready;

  cordic_fold #(.IN_W(IN_W), .XW(XW), .ZW(ZW), .FG(FRAC_GUARD)) u_fold (
    .clk(clk), .rst(rst), .take_i(take), .re_i(in_re), .im_i(in_im),
    .vld_o(fv), .x_o(fx), .y_o(fy), .z_o(fz)
  );

  if (SERIAL) begin : g_ser
    logic signed [XW-1:0] sx, sy, ax, ay, nx, ny;
    logic [ZW-1:0]        sz, az, nz;
    logic [SW-1:0]        cnt;
    logic                 busy, done, last;

    assign last = (cnt == SW'(ITERS - 1));

    always_comb begin
      ax = (cnt == '0) ? fx : sx;
      ay = (cnt == '0) ? fy : sy;
      az = (cnt == '0) ? fz : sz;
    end

    cordic_iter #(.XW(XW), .ZW(ZW), .SW(SW)) u_it (
      .x_i(ax), .y_i(ay), .z_i(az), .sh_i(cnt), .atan_i(atan_tab[cnt]),
      .x_o(nx), .y_o(ny), .z_o(nz)
    );

    always_ff @(posedge clk) begin
      if (busy) begin
        sx <= nx;
        sy <= ny;
        sz <= nz;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        busy <= 1'b0;
        done <= 1'b0;
        cnt  <= '0;
      end else begin
        done <= busy && last;
        if (take) begin
          busy <= 1'b1;
          cnt  <= '0;
        end else if (busy) begin
          if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
          end else begin
            cnt <= cnt + SW'(1);
          end
        end
      end
    end

    assign in_ready = !busy;
    assign rx = sx;
    assign ry = sy;
    assign rz = sz;
    assign rv = done;

    AST_SER_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R5
    AST_SER_READY_BACK: assert property (@(posedge clk) disable iff (rst)
      done |-> in_ready); // R6

  end else begin : g_pipe
    logic signed [XW-1:0] px [ITERS+1];
    logic signed [XW-1:0] py [ITERS+1];
    logic [ZW-1:0]        pz [ITERS+1];
    logic                 pv [ITERS+1];

    assign px[0] = fx;
    assign py[0] = fy;
    assign pz[0] = fz;
    assign pv[0] = fv;

    for (genvar g = 0; g < ITERS; g++) begin : g_st
      logic signed [XW-1:0] cx, cy;
      logic [ZW-1:0]        cz;
      logic signed [XW-1:0] qx [REGS_PER_ITER];
      logic signed [XW-1:0] qy [REGS_PER_ITER];
      logic [ZW-1:0]        qz [REGS_PER_ITER];
      logic                 qv [REGS_PER_ITER];

      cordic_iter #(.XW(XW), .ZW(ZW), .SW(SW)) u_it (
        .x_i(px[g]), .y_i(py[g]), .z_i(pz[g]), .sh_i(SW'(g)),
        .atan_i(atan_tab[g]), .x_o(cx), .y_o(cy), .z_o(cz)
      );

      always_ff @(posedge clk) begin
        qx[0] <= cx;
        qy[0] <= cy;
        qz[0] <= cz;
        for (int r = 1; r < REGS_PER_ITER; r++) begin
          qx[r] <= qx[r-1];
          qy[r] <= qy[r-1];
          qz[r] <= qz[r-1];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int r = 0; r < REGS_PER_ITER; r++) qv[r] <= 1'b0;
        end else begin
          qv[0] <= pv[g];
          for (int r = 1; r < REGS_PER_ITER; r++) qv[r] <= qv[r-1];
        end
      end

      assign px[g+1] = qx[REGS_PER_ITER-1];
      assign py[g+1] = qy[REGS_PER_ITER-1];
      assign pz[g+1] = qz[REGS_PER_ITER-1];
      assign pv[g+1] = qv[REGS_PER_ITER-1];
    end

    assign in_ready = 1'b1;
    assign rx = px[ITERS];
    assign ry = py[ITERS];
    assign rz = pz[ITERS];
    assign rv = pv[ITERS];
  end

  cordic_out #(
    .XW(XW), .ZW(ZW), .FG(FRAC_GUARD), .PG(PH_GUARD), .MAG_W(MAG_W),
    .PH_W(PH_W), .ITERS(ITERS), .GAIN_W(GAIN_W), .GAIN_COMP(GAIN_COMP),
    .ROUND(ROUND), .SATURATE(SATURATE)
  ) u_out (
    .clk(clk), .rst(rst), .vld_i(rv), .x_i(rx), .y_i(ry), .z_i(rz),
    .mag_o(out_mag), .ph_o(out_phase), .vld_o(out_valid)
  );

endmodule

// File: tb/sim_cordic_polar.sv
`timescale 1ns/1ps
module sim_cordic_polar;
  localparam int N     = 16;
  localparam int LAT_P = 2 * N + 1;
  localparam int LAT_S = N + 1;
  localparam real PI   = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic        a_v = 1'b0, b_v = 1'b0;
  logic        a_rdy, b_rdy, a_ov, b_ov;
  logic [15:0] a_mag, a_ph, b_mag, b_ph;

  cordic_polar #(.SERIAL(1'b0), .REGS_PER_ITER(2)) u0 (
    .clk(clk), .rst(rst), .in_re(a_re), .in_im(a_im), .in_valid(a_v),
    .in_ready(a_rdy), .out_mag(a_mag), .out_phase(a_ph), .out_valid(a_ov)
  );

  cordic_polar #(.SERIAL(1'b1), .GAIN_COMP(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_re(b_re), .in_im(b_im), .in_valid(b_v),
    .in_ready(b_rdy), .out_mag(b_mag), .out_phase(b_ph), .out_valid(b_ov)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int a_n = 0, b_n = 0;
  int a_cm [64], a_cp [64], a_cc [64];
  int b_cm [64], b_cp [64], b_cc [64];

  always @(negedge clk) begin
    if (!rst) begin
      if (a_ov && a_n < 64) begin
        a_cm[a_n] = int'(a_mag); a_cp[a_n] = int'(a_ph); a_cc[a_n] = cyc; a_n++;
      end
      if (b_ov && b_n < 64) begin
        b_cm[b_n] = int'(b_mag); b_cp[b_n] = int'(b_ph); b_cc[b_n] = cyc; b_n++;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp, input int tol);
    int d;
    d = got - exp;
    if (d < 0) d = -d;
    n_chk++;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, got, exp, tol);
    end
  endtask

  task automatic chk_ph(input string tag, input int got, input int exp, input int tol);
    int d;
    d = got - exp;
    if (d > 32768)  d -= 65536;
    if (d < -32768) d += 65536;
    if (d < 0) d = -d;
    n_chk++;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, got, exp, tol);
    end
  endtask

  function automatic real gain_k();
    real k;
    k = 1.0;
    for (int i = 0; i < N; i++) k = k * $sqrt(1.0 + 2.0 ** (-2 * i));
    return k;
  endfunction

  function automatic int exp_mag(input int re, input int im, input real scale);
    return $rtoi(scale * $sqrt(real'(re) * re + real'(im) * im) + 0.5);
  endfunction

  function automatic int exp_ph(input int re, input int im);
    real t;
    t = $atan2(real'(im), real'(re)) / (2.0 * PI);
    if (t < 0.0) t = t + 1.0;
    return $rtoi(t * 65536.0 + 0.5) % 65536;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 pipe valid in reset", int'(a_ov), 0, 0);
    chk("R1 serial valid in reset", int'(b_ov), 0, 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1 pipe valid after reset", int'(a_ov), 0, 0);
    chk("R1 serial valid after reset", int'(b_ov), 0, 0);
    chk("R1 serial ready after reset", int'(b_rdy), 1, 0);
    chk("R1 pipe ready after reset", int'(a_rdy), 1, 0);
  endtask

  task automatic t_pipe_burst();
    int vre [10] = '{20000, 0, -20000, 0, 12000, -7000, -30000, 9000, -32768, 6000};
    int vim [10] = '{0, 20000, 0, -20000, 9000, 15000, -25000, -31000, -32768, -4000};
    int acc [10];
    int base, rdy_low;
    base = a_n;
    rdy_low = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!a_rdy) rdy_low++;
      a_re = 16'(vre[k]); a_im = 16'(vim[k]); a_v = 1'b1;
      acc[k] = cyc + 1;
    end
    @(negedge clk) a_v = 1'b0;
    repeat (LAT_P + 8) @(negedge clk);
    chk("R4 ready held high in burst", rdy_low, 0, 0);
    chk("R4 one output per sample", a_n - base, 10, 0);
    for (int k = 0; k < 10; k++) begin
      if (base + k < a_n) begin
        chk("R4 pipelined latency", a_cc[base+k] - acc[k], LAT_P, 0);
        chk("R2 compensated magnitude", a_cm[base+k], exp_mag(vre[k], vim[k], 1.0), 3);
        chk_ph("R3 phase in turns", a_cp[base+k], exp_ph(vre[k], vim[k]), 4);
      end
    end
  endtask

  task automatic t_serial_basic();
    int acc, low, base;
    base = b_n;
    @(negedge clk);
    while (!b_rdy) @(negedge clk);
    b_re = 16'(10000); b_im = 16'(0); b_v = 1'b1;
    acc = cyc + 1;
    @(negedge clk) b_v = 1'b0;
    low = 0;
    while (!b_rdy && low < 100) begin
      low++;
      @(negedge clk);
    end
    chk("R6 ready low window", low, N, 0);
    repeat (6) @(negedge clk);
    chk("R5 serial one output", b_n - base, 1, 0);
    if (b_n > base) begin
      chk("R5 serial latency", b_cc[base] - acc, LAT_S, 0);
      chk("R7 raw magnitude carries gain", b_cm[base], exp_mag(10000, 0, gain_k()), 3);
      chk_ph("R3 serial phase zero", b_cp[base], 0, 4);
    end
  endtask

  task automatic t_serial_ignore();
    int base;
    base = b_n;
    @(negedge clk);
    while (!b_rdy) @(negedge clk);
    b_re = 16'(-5000); b_im = 16'(8000); b_v = 1'b1;
    @(negedge clk);
    b_re = 16'(20000); b_im = 16'(20000);
    repeat (10) @(negedge clk);
    b_v = 1'b0;
    repeat (N + 12) @(negedge clk);
    chk("R6 busy input ignored", b_n - base, 1, 0);
    if (b_n > base) begin
      chk("R6 first sample magnitude kept", b_cm[base], exp_mag(-5000, 8000, gain_k()), 3);
      chk_ph("R6 first sample phase kept", b_cp[base], exp_ph(-5000, 8000), 4);
    end
  endtask

  task automatic t_saturate();
    int base;
    base = b_n;
    @(negedge clk);
    while (!b_rdy) @(negedge clk);
    b_re = 16'h8000; b_im = 16'h8000; b_v = 1'b1;
    @(negedge clk) b_v = 1'b0;
    repeat (N + 6) @(negedge clk);
    chk("R8 saturation count", b_n - base, 1, 0);
    if (b_n > base) begin
      chk("R8 magnitude clamps to full scale", b_cm[base], 65535, 0);
      chk_ph("R3 corner phase", b_cp[base], 40960, 4);
    end
  endtask

  initial begin
    t_reset();
    t_pipe_burst();
    t_serial_basic();
    t_serial_ignore();
    t_saturate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule